// File: doc/BRIEF.md
# Model-Specific Register Access Permission Lookup

This block decides, for one guest access to a model-specific register, whether the access has to leave the guest and return to the host. A permission bitmap held in memory gives two bits per register: one for reads and one for writes. The 32-bit register index space is sparse. Three separate 8192-register ranges are each mapped onto their own 2 KB window of the bitmap. Any index outside those ranges always causes an exit.

A lookup starts with a one-cycle `start` strobe. The strobe carries the index, the access kind and the bitmap base address. The lookup is also qualified by a guest-active flag and a global enable for register-access interception. For an index inside a mapped range, the block fetches exactly one byte through a request/valid read port. It then selects one bit of that byte and reports the verdict with a one-cycle `done` pulse. On an exit it also returns the value for the first exit-information field.

Top module: `msr_perm_check`

## Requirements
- R1: After reset, `done`, `exit_o` and `rd_req` are all low.
- R2: When `guest_on` or `icpt_en` is low at the start strobe, the lookup completes one cycle later with `exit_o` low, `exit_info` zero and no memory request.
- R3: An index in none of the three mapped ranges completes one cycle after the strobe with `exit_o` high, without any memory request.
- R4: For indices 0x0000_0000..0x0000_1FFF, the byte address requested is base + 0 + floor(p/8), where p = (index mod 8192)*2 + op. Here op is 0 for a read and 1 for a write.
- R5: Indices 0xC000_0000..0xC000_1FFF use window offset 2048, and indices 0xC001_0000..0xC001_1FFF use window offset 4096, in the same formula. The edges of each range are mapped, and the indices just beyond them are not.
- R6: For a mapped index, `exit_o` equals bit (p mod 8) of the returned byte, where bit 0 is the least significant bit.
- R7: On an exit, `exit_info` equals op (0 for a read, 1 for a write), zero-extended. When there is no exit, it is zero.
- R8: A mapped lookup raises `rd_req` for exactly one cycle. `done` pulses exactly one cycle after the cycle in which `rd_valid` is high.
- R9: A start strobe that arrives while a lookup waits for its read data is ignored. It produces no request and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle lookup strobe |
| msr_idx | input | 32 | Register index being accessed |
| is_write | input | 1 | Access kind: 0 read, 1 write |
| map_base | input | ADDR_W | Byte address of the permission bitmap |
| guest_on | input | 1 | Guest context active |
| icpt_en | input | 1 | Register-access interception enabled |
| rd_req | output | 1 | One-cycle byte read request |
| rd_addr | output | ADDR_W | Byte address of the read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Returned byte |
| done | output | 1 | One-cycle completion pulse |
| exit_o | output | 1 | Access must exit to the host (valid with `done`) |
| exit_info | output | INFO_W | Exit information: the access kind on an exit |

## Verification
The assertions check the following on every cycle:
- the request stays a single-cycle pulse;
- `done` follows returned data by exactly one cycle;
- the disabled and unmapped paths finish the next cycle without touching memory;
- a strobe during the wait raises no request;
- `exit_info` is zero whenever there is no exit.

Only the bench's scenarios can show the rest. That covers the byte address chosen for each window, the range edges, the bit picked from the byte for each access kind, and the absence of a stray completion after a swallowed strobe. Those results depend on the bitmap contents and on an address computed independently.

// File: rtl/msr_perm_check.sv
module msr_perm_check #(
  parameter int ADDR_W = 48,
  parameter int INFO_W = 64,
  parameter int WIN_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       msr_idx,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] map_base,
  input  logic              guest_on,
  input  logic              icpt_en,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              exit_o,
  output logic [INFO_W-1:0] exit_info
);

  localparam logic [18:0] RANGE_LO  = 19'h00000;
  localparam logic [18:0] RANGE_MID = 19'h60000;
  localparam logic [18:0] RANGE_HI  = 19'h60008;

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t st;

  logic       op_q;
  logic [2:0] bit_q;

  wire in_lo  = msr_idx[31:13] == RANGE_LO;
  wire in_mid = msr_idx[31:13] == RANGE_MID;
  wire in_hi  = msr_idx[31:13] == RANGE_HI;
  wire mapped = in_lo | in_mid | in_hi;
  wire active = guest_on & icpt_en;

  wire [ADDR_W-1:0] win_off = in_mid ? ADDR_W'(WIN_BYTES) :
                              in_hi  ? ADDR_W'(2 * WIN_BYTES) : '0;
  wire [ADDR_W-1:0] byte_addr = map_base + win_off + ADDR_W'(msr_idx[12:2]);
  wire              perm_bit  = rd_data[bit_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      done      <= 1'b0;
      exit_o    <= 1'b0;
      exit_info <= '0;
      op_q      <= 1'b0;
      bit_q     <= '0;
    end else begin
      rd_req <= 1'b0;
      done   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q  <= is_write;
          bit_q <= {msr_idx[1:0], is_write};
          if (!active) begin
            done      <= 1'b1;
            exit_o    <= 1'b0;
            exit_info <= '0;
          end else if (!mapped) begin
            done      <= 1'b1;
            exit_o    <= 1'b1;
            exit_info <= INFO_W'(is_write);
          end else begin
            rd_req  <= 1'b1;
            rd_addr <= byte_addr;
            st      <= S_WAIT;
          end
        end
        S_WAIT: if (rd_valid) begin
          done      <= 1'b1;
          exit_o    <= perm_bit;
          exit_info <= perm_bit ? INFO_W'(op_q) : '0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  off_no_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !active) |=> (done && !exit_o && !rd_req));

  // R3
  unmapped_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && active && !mapped) |=> (done && exit_o && !rd_req));

  // R7
  info_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !exit_o) |-> (exit_info == '0));

  // R7
  info_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exit_o) |-> (exit_info == INFO_W'(op_q)));

  // R8
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R8
  valid_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && rd_valid) |=> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !rd_valid && start) |=> (!rd_req && !done));

endmodule

// File: tb/tb_msr_perm_check.sv
module tb_msr_perm_check;
  localparam int ADDR_W = 48;
  localparam int INFO_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] msr_idx = '0;
  logic is_write = 1'b0;
  logic [ADDR_W-1:0] map_base = '0;
  logic guest_on = 1'b0;
  logic icpt_en = 1'b0;
  logic rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic rd_valid = 1'b0;
  logic [7:0] rd_data = '0;
  logic done;
  logic exit_o;
  logic [INFO_W-1:0] exit_info;

  always #10 clk = ~clk;

  msr_perm_check #(.ADDR_W(ADDR_W), .INFO_W(INFO_W), .WIN_BYTES(2048)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msr_idx(msr_idx), .is_write(is_write),
    .map_base(map_base), .guest_on(guest_on), .icpt_en(icpt_en), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .exit_o(exit_o), .exit_info(exit_info));

  typedef struct {
    string       tag;
    logic        ex;
    logic [63:0] info;
    int          reads;
    logic [ADDR_W-1:0] addr;
    int          start_cyc;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int nreads = 0;
  int reads_mark = 0;
  int lat = 1;
  int pend = 0;
  int valid_cyc = -10;
  logic [ADDR_W-1:0] pend_addr = '0;
  logic [ADDR_W-1:0] last_addr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_at(logic [ADDR_W-1:0] a);
    return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
  endfunction

  // memory responder
  always @(negedge clk) begin
    rd_valid = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        rd_valid = 1'b1;
        rd_data = mem_at(pend_addr);
        valid_cyc = cyc;
      end
    end
    if (rd_req) begin
      pend_addr = rd_addr;
      last_addr = rd_addr;
      pend = lat;
      nreads = nreads + 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      checks = checks + 1;
      if (q.size() == 0) begin
        fails = fails + 1;
        $display("FAIL R9 unexpected done: actual done=1 expected done=0");
      end else begin
        exp_t e;
        int got_reads;
        int want_cyc;
        logic ok;
        e = q.pop_front();
        got_reads = nreads - reads_mark;
        reads_mark = nreads;
        want_cyc = (e.reads == 0) ? e.start_cyc + 1 : valid_cyc + 1;
        ok = (exit_o === e.ex) && (exit_info === e.info) && (got_reads == e.reads)
             && (cyc == want_cyc) && (e.reads == 0 || last_addr === e.addr);
        if (!ok) begin
          fails = fails + 1;
          $display("FAIL %s: actual exit=%0b info=%0h reads=%0d addr=%0h cyc=%0d expected exit=%0b info=%0h reads=%0d addr=%0h cyc=%0d",
                   e.tag, exit_o, exit_info, got_reads, last_addr, cyc,
                   e.ex, e.info, e.reads, e.addr, want_cyc);
        end
      end
    end
  end

  task automatic lookup(string tag, logic [31:0] idx, logic op, logic g, logic en,
                        logic [ADDR_W-1:0] base, int l, bit dup);
    exp_t e;
    int off;
    logic [31:0] p;
    e.tag = tag;
    e.ex = 1'b0;
    e.info = '0;
    e.reads = 0;
    e.addr = '0;
    off = -1;
    if (idx <= 32'h0000_1FFF) off = 0;
    else if (idx >= 32'hC000_0000 && idx <= 32'hC000_1FFF) off = 2048;
    else if (idx >= 32'hC001_0000 && idx <= 32'hC001_1FFF) off = 4096;
    if (!(g && en)) begin
      e.ex = 1'b0;
    end else if (off < 0) begin
      e.ex = 1'b1;
      e.info = 64'(op);
    end else begin
      p = (idx & 32'h1FFF) * 2 + 32'(op);
      e.reads = 1;
      e.addr = base + ADDR_W'(off) + ADDR_W'(p / 8);
      e.ex = mem_at(e.addr)[p % 8];
      e.info = e.ex ? 64'(op) : '0;
    end
    lat = l;
    @(negedge clk);
    e.start_cyc = cyc;
    q.push_back(e);
    msr_idx = idx; is_write = op; guest_on = g; icpt_en = en; map_base = base;
    start = 1'b1;
    @(negedge clk);
    if (dup) begin
      msr_idx = 32'hFFFF_FFFF; is_write = ~op;
      @(negedge clk);
      @(negedge clk);
    end
    start = 1'b0;
    for (int i = 0; i < 20 && q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks = checks + 1;
    if (done !== 1'b0 || exit_o !== 1'b0 || rd_req !== 1'b0) begin
      fails = fails + 1;
      $display("FAIL R1: actual done=%b exit=%b req=%b expected 0 0 0", done, exit_o, rd_req);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R2 disabled paths
    lookup("R2 guest off", 32'h0000_0010, 1'b1, 1'b0, 1'b1, 48'h1000, 1, 0);
    lookup("R2 intercept off", 32'hC000_0080, 1'b0, 1'b1, 1'b0, 48'h1000, 1, 0);
    lookup("R2 off unmapped", 32'h8000_0000, 1'b1, 1'b1, 1'b0, 48'h1000, 1, 0);
    // R3 unmapped indices and range edges, R7 info
    lookup("R3 R7 read unmapped", 32'h0000_2000, 1'b0, 1'b1, 1'b1, 48'h2000, 1, 0);
    lookup("R3 R7 write unmapped", 32'hBFFF_FFFF, 1'b1, 1'b1, 1'b1, 48'h2000, 1, 0);
    lookup("R3 R5 above mid", 32'hC000_2000, 1'b1, 1'b1, 1'b1, 48'h2000, 1, 0);
    lookup("R3 R5 above hi", 32'hC001_2000, 1'b0, 1'b1, 1'b1, 48'h2000, 1, 0);
    lookup("R3 R5 gap", 32'hC000_FFFF, 1'b1, 1'b1, 1'b1, 48'h2000, 1, 0);
    // R4 R6 R8 low window
    lookup("R4 R6 low first rd", 32'h0000_0000, 1'b0, 1'b1, 1'b1, 48'h3000, 1, 0);
    lookup("R4 R6 low last wr", 32'h0000_1FFF, 1'b1, 1'b1, 1'b1, 48'h3000, 2, 0);
    // R5 other windows at edges
    lookup("R5 mid first", 32'hC000_0000, 1'b1, 1'b1, 1'b1, 48'h3000, 1, 0);
    lookup("R5 mid last", 32'hC000_1FFF, 1'b0, 1'b1, 1'b1, 48'h3000, 3, 0);
    lookup("R5 hi first", 32'hC001_0000, 1'b0, 1'b1, 1'b1, 48'h3000, 2, 0);
    lookup("R5 hi last", 32'hC001_1FFF, 1'b1, 1'b1, 1'b1, 48'h3000, 1, 0);
    // R9 strobe while busy
    lookup("R9 busy strobe", 32'h0000_0123, 1'b1, 1'b1, 1'b1, 48'h5000, 3, 1);
    // R6 R7 R8 sweep across bit positions, ops, latencies
    for (int k = 0; k < 48; k++) begin
      logic [31:0] ix;
      logic [31:0] lo;
      lo = 32'($urandom_range(0, 8191));
      case (k % 3)
        0: ix = lo;
        1: ix = 32'hC000_0000 | lo;
        default: ix = 32'hC001_0000 | lo;
      endcase
      lookup("R6 R7 R8 sweep", ix, 1'(k), 1'b1, 1'b1,
             ADDR_W'(48'h10_0000 + (k * 48'h800)), 1 + (k % 3), 0);
    end
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule